// File: doc/BRIEF.md
# Multi-Channel DMA Control Write and Start Logic

This block sits between the register file of a four-channel DMA controller and its transfer engine. When software writes a channel's 16-bit control word, the block decides whether the write arms the channel. If it does, the block takes a snapshot of that channel's source address, destination address and word count, and decodes the transfer options from the control word. It then holds the resulting parameter set steady for the engine. The engine itself is outside this block. It receives the latched parameters, a one-cycle start pulse for transfers that begin at once, and a one-cycle clear pulse when a channel is switched off.

Some rules depend on the channel. Channels 0 to 2 have a 14-bit count, and channel 3 has a full 16-bit count. A zero count stands for the largest count the channel can hold. Channels 1 and 2 can feed an audio FIFO. In that mode their width, count and destination behaviour are forced to fixed values, and the destination address picks which of two FIFOs is fed. A sticky flag records that a channel 3 transfer looked like a large serial EEPROM access.

All results are registered. Parameters, pulses and the readback word appear on the outputs one clock after the write cycle. Reset is asynchronous and active low, and its release is synchronised inside the block, so the block becomes writable two clock edges after `rst_n` rises.

Top module: `dma_ctl_start`

## Requirements
- R1: A control write with bit 15 set latches a new parameter set only when the channel is inactive. If the channel is already active, its latched parameters and active state stay unchanged.
- R2: When the parameters are latched, the control word is decoded into these fields: destination step from bits 6:5, source step from bits 8:7, repeat from bit 9, 32-bit width from bit 10, start timing from bits 13:12 and interrupt request from bit 14. The step codes are 0 increment, 1 decrement, 2 fixed and 3 increment with reload.
- R3: The latched source and destination are the channel's 32-bit address inputs with the upper four bits removed, which leaves 28 bits.
- R4: On channels 0 to 2, the count is the low 14 bits of the count input. A result of zero becomes 0x4000.
- R5: On channel 3, the count is the full 16-bit input. A value of zero becomes 0x10000.
- R6: On channels 1 and 2 with start timing 3 (special), the latched set has 32-bit width, a count of 4 and destination step 2 (fixed). The control word's values for these fields are ignored.
- R7: The audio FIFO association is 2 (FIFO B) when the masked destination equals 0x40000A4, and 1 (FIFO A) for any other destination. It applies only in the R6 case. Every other latch gives 0 (none).
- R8: A control write with bit 15 clear makes the channel inactive and sets its FIFO association to 0. It also raises that channel's clear pulse for exactly one cycle.
- R9: A latch with start timing 0 (immediate) raises that channel's start pulse for exactly one cycle, in the same cycle the parameters appear. Timing codes 1, 2 and 3 (vertical blank, horizontal blank, special) raise no pulse.
- R10: Every control write stores the full written word in that channel's readback output, whether or not bit 15 is set and whether or not a latch happens.
- R11: A latch on channel 3 sets the sticky large-EEPROM flag when destination bits 27:24 equal 0xD and the low five bits of the count input equal 17. A matching write on another channel does not set it. Once set, the flag stays set until reset.
- R12: After reset, all channels are inactive, every readback word is zero, no pulse is active and the EEPROM flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_ch | input | 2 | Channel addressed by the write |
| wr_data | input | 16 | Control word written |
| src_in | input | 128 | Source address register of each channel, 32 bits each |
| dst_in | input | 128 | Destination address register of each channel, 32 bits each |
| cnt_in | input | 64 | Word count register of each channel, 16 bits each |
| active_o | output | 4 | Channel armed |
| start_o | output | 4 | One-cycle immediate start pulse |
| clear_o | output | 4 | One-cycle channel disable pulse |
| ctl_rd_o | output | 64 | Readback control word of each channel |
| src_o | output | 112 | Latched 28-bit source of each channel |
| dst_o | output | 112 | Latched 28-bit destination of each channel |
| cnt_o | output | 68 | Latched 17-bit normalised count of each channel |
| dst_step_o | output | 8 | Destination step code of each channel |
| src_step_o | output | 8 | Source step code of each channel |
| repeat_o | output | 4 | Repeat flag of each channel |
| word32_o | output | 4 | 32-bit unit flag of each channel |
| timing_o | output | 8 | Start timing code of each channel |
| irq_o | output | 4 | Interrupt-on-completion flag of each channel |
| fifo_o | output | 8 | Audio FIFO association of each channel |
| eeprom_big_o | output | 1 | Sticky large-EEPROM flag |

## Verification
The bench uses the default build of four channels, so the last channel is channel 3 and the audio-capable channels are 1 and 2. This puts both count normalisation rules and the forced audio configuration within reach, and lets each be compared with channels that lack them. The sweep covers every channel and every start timing code. For each pair it uses six count values, chosen to hit zero, the 14-bit mask boundary, 17 and all-ones, and two destinations: the FIFO B address and an address in the EEPROM page. It re-arms each channel while active and disarms it between cases, so the sticky EEPROM flag, the held parameters and the readback word are all observed on the ports.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int ADDR_W      = 28;
  localparam int RAW_W       = 32;
  localparam int CTL_W       = 16;
  localparam int RAW_CNT_W   = 16;
  localparam int SMALL_CNT_W = 14;
  localparam int CNT_W       = RAW_CNT_W + 1;

  localparam int EN_BIT   = 15;
  localparam int IRQ_BIT  = 14;
  localparam int TM_LSB   = 12;
  localparam int WORD_BIT = 10;
  localparam int RPT_BIT  = 9;
  localparam int SRC_LSB  = 7;
  localparam int DST_LSB  = 5;

  typedef enum logic [1:0] {
    TM_IMM     = 2'd0,
    TM_VBLANK  = 2'd1,
    TM_HBLANK  = 2'd2,
    TM_SPECIAL = 2'd3
  } timing_e;

  typedef enum logic [1:0] {
    STEP_INC        = 2'd0,
    STEP_DEC        = 2'd1,
    STEP_FIXED      = 2'd2,
    STEP_INC_RELOAD = 2'd3
  } step_e;

  typedef enum logic [1:0] {
    FIFO_NONE = 2'd0,
    FIFO_A    = 2'd1,
    FIFO_B    = 2'd2,
    FIFO_RSVD = 2'd3
  } fifo_e;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [CNT_W-1:0]  cnt;
    step_e             dst_step;
    step_e             src_step;
    logic              rpt;
    logic              word32;
    timing_e           timing;
    logic              irq;
    fifo_e             fifo;
  } chan_cfg_t;
endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
  import dma_ctl_pkg::*;
#(
  parameter int              CH_IDX      = 0,
  parameter int              NUM_CH      = 4,
  parameter int              SND_LO      = 1,
  parameter int              SND_HI      = 2,
  parameter logic [ADDR_W-1:0] FIFO_B_ADDR = 28'h40000A4,
  parameter logic [3:0]      EE_PAGE     = 4'hD,
  parameter logic [4:0]      EE_CODE     = 5'd17
) (
  input  logic [CTL_W-1:0]     ctl,
  input  logic [RAW_W-1:0]     src_raw,
  input  logic [RAW_W-1:0]     dst_raw,
  input  logic [RAW_CNT_W-1:0] cnt_raw,
  output chan_cfg_t            cfg,
  output logic                 eeprom_hit
);
  localparam bit IS_LAST = (CH_IDX == NUM_CH - 1);
  localparam bit SND_OK  = (CH_IDX >= SND_LO) && (CH_IDX <= SND_HI);

  logic [CNT_W-1:0]  cnt_norm;
  logic [ADDR_W-1:0] dst_m;
  timing_e           tm;
  logic              snd_mode;

  assign dst_m = dst_raw[ADDR_W-1:0];
  assign tm    = timing_e'(ctl[TM_LSB +: 2]);

  generate
    if (IS_LAST) begin : g_big_cnt
      assign cnt_norm   = (cnt_raw == '0) ? CNT_W'(1 << RAW_CNT_W) : CNT_W'(cnt_raw);
      assign eeprom_hit = (dst_m[ADDR_W-1 -: 4] == EE_PAGE) && (cnt_raw[4:0] == EE_CODE);
    end else begin : g_small_cnt
      logic [SMALL_CNT_W-1:0] c_m;
      assign c_m        = cnt_raw[SMALL_CNT_W-1:0];
      assign cnt_norm   = (c_m == '0) ? CNT_W'(1 << SMALL_CNT_W) : CNT_W'(c_m);
      assign eeprom_hit = 1'b0;
    end
    if (SND_OK) begin : g_snd
      assign snd_mode = (tm == TM_SPECIAL);
    end else begin : g_nosnd
      assign snd_mode = 1'b0;
    end
  endgenerate

  always_comb begin
    cfg.src      = src_raw[ADDR_W-1:0];
    cfg.dst      = dst_m;
    cfg.src_step = step_e'(ctl[SRC_LSB +: 2]);
    cfg.rpt      = ctl[RPT_BIT];
    cfg.timing   = tm;
    cfg.irq      = ctl[IRQ_BIT];
    if (snd_mode) begin
      cfg.cnt      = CNT_W'(4);
      cfg.word32   = 1'b1;
      cfg.dst_step = STEP_FIXED;
      cfg.fifo     = (dst_m == FIFO_B_ADDR) ? FIFO_B : FIFO_A;
    end else begin
      cfg.cnt      = cnt_norm;
      cfg.word32   = ctl[WORD_BIT];
      cfg.dst_step = step_e'(ctl[DST_LSB +: 2]);
      cfg.fifo     = FIFO_NONE;
    end
  end
endmodule

// File: rtl/dma_ctl_chan.sv
module dma_ctl_chan
  import dma_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CTL_W-1:0] wr_data,
  input  chan_cfg_t        cfg_in,
  output chan_cfg_t        cfg_q,
  output logic             active_q,
  output logic             start_q,
  output logic             clear_q,
  output logic [CTL_W-1:0] ctl_q
);
  chan_cfg_t        cfg_n;
  logic             active_n;
  logic             start_n;
  logic             clear_n;
  logic [CTL_W-1:0] ctl_n;
  logic             load_cfg;

  always_comb begin
    cfg_n    = cfg_q;
    active_n = active_q;
    ctl_n    = ctl_q;
    start_n  = 1'b0;
    clear_n  = 1'b0;
    load_cfg = 1'b0;
    if (wr) begin
      ctl_n = wr_data;
      if (wr_data[EN_BIT]) begin
        if (!active_q) begin
          load_cfg = 1'b1;
          active_n = 1'b1;
          cfg_n    = cfg_in;
          start_n  = (timing_e'(wr_data[TM_LSB +: 2]) == TM_IMM);
        end
      end else begin
        active_n   = 1'b0;
        cfg_n.fifo = FIFO_NONE;
        clear_n    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      start_q  <= 1'b0;
      clear_q  <= 1'b0;
      ctl_q    <= '0;
    end else begin
      active_q <= active_n;
      start_q  <= start_n;
      clear_q  <= clear_n;
      if (wr) ctl_q <= ctl_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (load_cfg || (wr && !wr_data[EN_BIT])) begin
      cfg_q <= cfg_n;
    end
  end

  // R9
  start_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> active_q);
  // R9
  start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  // R1
  params_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q)) |-> $stable(cfg_q));
  // R8
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_q |-> (!active_q && cfg_q.fifo == FIFO_NONE));
  // R4
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cfg_q.cnt != '0));
endmodule

// File: rtl/dma_ctl_start.sv
module dma_ctl_start
  import dma_ctl_pkg::*;
#(
  parameter int                NUM_CH      = 4,
  parameter int                SND_LO      = 1,
  parameter int                SND_HI      = 2,
  parameter logic [ADDR_W-1:0] FIFO_B_ADDR = 28'h40000A4,
  parameter logic [3:0]        EE_PAGE     = 4'hD,
  parameter logic [4:0]        EE_CODE     = 5'd17,
  localparam int               CH_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [CH_W-1:0]             wr_ch,
  input  logic [CTL_W-1:0]            wr_data,
  input  logic [NUM_CH*RAW_W-1:0]     src_in,
  input  logic [NUM_CH*RAW_W-1:0]     dst_in,
  input  logic [NUM_CH*RAW_CNT_W-1:0] cnt_in,
  output logic [NUM_CH-1:0]           active_o,
  output logic [NUM_CH-1:0]           start_o,
  output logic [NUM_CH-1:0]           clear_o,
  output logic [NUM_CH*CTL_W-1:0]     ctl_rd_o,
  output logic [NUM_CH*ADDR_W-1:0]    src_o,
  output logic [NUM_CH*ADDR_W-1:0]    dst_o,
  output logic [NUM_CH*CNT_W-1:0]     cnt_o,
  output logic [NUM_CH*2-1:0]         dst_step_o,
  output logic [NUM_CH*2-1:0]         src_step_o,
  output logic [NUM_CH-1:0]           repeat_o,
  output logic [NUM_CH-1:0]           word32_o,
  output logic [NUM_CH*2-1:0]         timing_o,
  output logic [NUM_CH-1:0]           irq_o,
  output logic [NUM_CH*2-1:0]         fifo_o,
  output logic                        eeprom_big_o
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [NUM_CH-1:0] wr_sel;
  logic [NUM_CH-1:0] ee_hit;
  logic [NUM_CH-1:0] active_q;
  chan_cfg_t         cfg_dec [NUM_CH];
  chan_cfg_t         cfg_q   [NUM_CH];
  logic              ee_set;
  logic              ee_n;
  logic              ee_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  genvar i;
  generate
    for (i = 0; i < NUM_CH; i++) begin : g_ch
      assign wr_sel[i] = wr_en && (wr_ch == CH_W'(i));

      dma_ctl_decode #(
        .CH_IDX(i), .NUM_CH(NUM_CH), .SND_LO(SND_LO), .SND_HI(SND_HI),
        .FIFO_B_ADDR(FIFO_B_ADDR), .EE_PAGE(EE_PAGE), .EE_CODE(EE_CODE)
      ) u_dec (
        .ctl(wr_data),
        .src_raw(src_in[i*RAW_W +: RAW_W]),
        .dst_raw(dst_in[i*RAW_W +: RAW_W]),
        .cnt_raw(cnt_in[i*RAW_CNT_W +: RAW_CNT_W]),
        .cfg(cfg_dec[i]),
        .eeprom_hit(ee_hit[i])
      );

      dma_ctl_chan u_chan (
        .clk(clk), .rst_n(rst_int_n), .wr(wr_sel[i]), .wr_data(wr_data),
        .cfg_in(cfg_dec[i]), .cfg_q(cfg_q[i]), .active_q(active_q[i]),
        .start_q(start_o[i]), .clear_q(clear_o[i]),
        .ctl_q(ctl_rd_o[i*CTL_W +: CTL_W])
      );

      assign active_o[i]                = active_q[i];
      assign src_o[i*ADDR_W +: ADDR_W]  = cfg_q[i].src;
      assign dst_o[i*ADDR_W +: ADDR_W]  = cfg_q[i].dst;
      assign cnt_o[i*CNT_W +: CNT_W]    = cfg_q[i].cnt;
      assign dst_step_o[i*2 +: 2]       = cfg_q[i].dst_step;
      assign src_step_o[i*2 +: 2]       = cfg_q[i].src_step;
      assign repeat_o[i]                = cfg_q[i].rpt;
      assign word32_o[i]                = cfg_q[i].word32;
      assign timing_o[i*2 +: 2]         = cfg_q[i].timing;
      assign irq_o[i]                   = cfg_q[i].irq;
      assign fifo_o[i*2 +: 2]           = cfg_q[i].fifo;

      // R6
      snd_force_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
        (cfg_q[i].fifo != FIFO_NONE) |->
          (cfg_q[i].word32 && cfg_q[i].cnt == CNT_W'(4) && cfg_q[i].dst_step == STEP_FIXED));
    end
  endgenerate

  always_comb begin
    ee_set = |(wr_sel & ee_hit & ~active_q) && wr_data[EN_BIT];
    ee_n   = ee_q | ee_set;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ee_q <= 1'b0;
    else            ee_q <= ee_n;
  end
  assign eeprom_big_o = ee_q;

  // R11
  ee_sticky_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ee_q |=> ee_q);
  // R8
  clear_start_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (clear_o & start_o) == '0);
endmodule

// File: tb/dma_ctl_start_test.sv
module dma_ctl_start_test;
  localparam int NCH = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_en;
  logic [1:0]       wr_ch;
  logic [15:0]      wr_data;
  logic [NCH*32-1:0] src_in, dst_in;
  logic [NCH*16-1:0] cnt_in;
  logic [NCH-1:0]   active_o, start_o, clear_o, repeat_o, word32_o, irq_o;
  logic [NCH*16-1:0] ctl_rd_o;
  logic [NCH*28-1:0] src_o, dst_o;
  logic [NCH*17-1:0] cnt_o;
  logic [NCH*2-1:0] dst_step_o, src_step_o, timing_o, fifo_o;
  logic             eeprom_big_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dma_ctl_start uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in),
    .active_o(active_o), .start_o(start_o), .clear_o(clear_o), .ctl_rd_o(ctl_rd_o),
    .src_o(src_o), .dst_o(dst_o), .cnt_o(cnt_o), .dst_step_o(dst_step_o),
    .src_step_o(src_step_o), .repeat_o(repeat_o), .word32_o(word32_o),
    .timing_o(timing_o), .irq_o(irq_o), .fifo_o(fifo_o), .eeprom_big_o(eeprom_big_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input int ch, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 2'(ch); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] cnts [6];
    logic [31:0] dsts [2];
    logic        exp_ee;
    int          k;
    cnts[0] = 16'h0000; cnts[1] = 16'h0001; cnts[2] = 16'h0011;
    cnts[3] = 16'h3FFF; cnts[4] = 16'hC000; cnts[5] = 16'hFFFF;
    dsts[0] = 32'hF40000A4; dsts[1] = 32'h3D000100;
    exp_ee = 1'b0; k = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_ch = '0; wr_data = '0;
    src_in = '0; dst_in = '0; cnt_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 active", 64'(active_o), 0);
    chk("R12 readback", 64'(ctl_rd_o), 0);
    chk("R12 pulses", 64'({start_o, clear_o}), 0);
    chk("R12 eeprom", 64'(eeprom_big_o), 0);

    for (int ch = 0; ch < NCH; ch++) begin
      for (int t = 0; t < 4; t++) begin
        for (int ci = 0; ci < 6; ci++) begin
          for (int di = 0; di < 2; di++) begin
            logic [15:0] ctl, ctl2, dis, cr;
            logic [31:0] sr, dr;
            logic [27:0] dm;
            logic [1:0]  dstm, srcm;
            logic        rpt, wd, irq, snd;
            logic [16:0] ecnt;
            logic [1:0]  efifo;
            k++;
            dstm = 2'(k % 4); srcm = 2'((k / 4) % 4);
            rpt = k[4]; wd = k[5]; irq = k[6];
            ctl = 16'h8000 | (16'(irq) << 14) | (16'(t) << 12) | (16'(k & 1) << 11) |
                  (16'(wd) << 10) | (16'(rpt) << 9) | (16'(srcm) << 7) |
                  (16'(dstm) << 5) | 16'(k & 31);
            dis = 16'(k * 16'h0123) & 16'h7FFF;
            sr = 32'hA0000000 | 32'(k * 32'h00111);
            dr = dsts[di]; cr = cnts[ci]; dm = dr[27:0];

            // R8 disable: clear pulse, inactive, no fifo; R10 readback
            do_write(ch, dis);
            chk("R8 active after disable", 64'(active_o[ch]), 0);
            chk("R8 fifo after disable", 64'(fifo_o[ch*2 +: 2]), 0);
            chk("R8 clear pulse", 64'(clear_o), 64'(1 << ch));
            chk("R10 readback disable", 64'(ctl_rd_o[ch*16 +: 16]), 64'(dis));
            @(negedge clk);
            chk("R8 clear one cycle", 64'(clear_o), 0);

            src_in = {NCH{sr}}; dst_in = {NCH{dr}}; cnt_in = {NCH{cr}};
            snd = (ch == 1 || ch == 2) && t == 3;
            if (snd) ecnt = 17'd4;
            else if (ch == 3) ecnt = (cr == 0) ? 17'h10000 : 17'(cr);
            else ecnt = ((cr & 16'h3FFF) == 0) ? 17'h04000 : 17'(cr & 16'h3FFF);
            efifo = snd ? ((dm == 28'h40000A4) ? 2'd2 : 2'd1) : 2'd0;
            if (ch == 3 && dm[27:24] == 4'hD && cr[4:0] == 5'd17) exp_ee = 1'b1;

            do_write(ch, ctl);
            chk("R1 active after enable", 64'(active_o[ch]), 1);
            chk("R3 source", 64'(src_o[ch*28 +: 28]), 64'(sr[27:0]));
            chk("R3 destination", 64'(dst_o[ch*28 +: 28]), 64'(dm));
            chk(ch == 3 ? "R5 count" : "R4 count", 64'(cnt_o[ch*17 +: 17]), 64'(ecnt));
            chk("R2 src step", 64'(src_step_o[ch*2 +: 2]), 64'(srcm));
            chk("R2 repeat", 64'(repeat_o[ch]), 64'(rpt));
            chk("R2 timing", 64'(timing_o[ch*2 +: 2]), 64'(t));
            chk("R2 irq", 64'(irq_o[ch]), 64'(irq));
            chk("R6 dst step", 64'(dst_step_o[ch*2 +: 2]), snd ? 64'd2 : 64'(dstm));
            chk("R6 word32", 64'(word32_o[ch]), snd ? 64'd1 : 64'(wd));
            chk("R7 fifo", 64'(fifo_o[ch*2 +: 2]), 64'(efifo));
            chk("R9 start pulse", 64'(start_o), (t == 0) ? 64'(1 << ch) : 64'd0);
            chk("R11 eeprom flag", 64'(eeprom_big_o), 64'(exp_ee));
            chk("R10 readback enable", 64'(ctl_rd_o[ch*16 +: 16]), 64'(ctl));
            @(negedge clk);
            chk("R9 start one cycle", 64'(start_o), 0);

            // R1 re-enable while active: parameters held, readback updated
            ctl2 = ctl ^ 16'h47E0;
            src_in = ~src_in; dst_in = {NCH{32'h0D000000}}; cnt_in = {NCH{16'h0011}};
            do_write(ch, ctl2);
            chk("R1 held source", 64'(src_o[ch*28 +: 28]), 64'(sr[27:0]));
            chk("R1 held count", 64'(cnt_o[ch*17 +: 17]), 64'(ecnt));
            chk("R1 held src step", 64'(src_step_o[ch*2 +: 2]), 64'(srcm));
            chk("R1 no restart", 64'(start_o), 0);
            chk("R11 no set when active", 64'(eeprom_big_o), 64'(exp_ee));
            chk("R10 readback rewrite", 64'(ctl_rd_o[ch*16 +: 16]), 64'(ctl2));
          end
        end
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule